// File: doc/BRIEF.md
# Reset Controller with Sticky Cause Log

This block gathers reset requests from every source on the chip and turns each accepted request into a reset pulse of fixed length. The sources are an external reset pin, the power-on reset, a brown-out detector event, a watchdog request, a debugger request, a processor system-reset request, and two software triggers that need an exact key. Each accepted request also sets its own bit in a cause log. The log is sticky: it survives the reset it records, and it collects causes until software clears it or power is removed.

Two reset outputs leave the block. The full reset covers the whole system. The partial reset is driven only by the software partial trigger. The block also drives a static reset for the trace port and a brown-out interrupt. Software reaches the block through a word-addressed register bus with combinational read data. Brown-out and watchdog events cause a reset only when their configuration enables are set. A brown-out event always sets the interrupt status, so the interrupt can stand in for the reset. All state is cleared only by the power-on reset input.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After `por_n_i` is released, `rst_full_o` stays high for exactly 8 sampled cycles. The cause log then reads 0x02 at offset 0x0C. Configuration (0x00), trace reset (0x14), interrupt enable (0x200) and interrupt status (0x204) all read 0.
- R2: A one-cycle request on the external, debugger or system-reset input gives an 8-cycle `rst_full_o` pulse, starting on the edge that samples the request. Each request sets its cause bit: bit 0 for external, bit 5 for debugger, bit 3 for system reset.
- R3: Configuration offset 0x00: bit 0 enables the brown-out reset and bit 1 enables the watchdog reset. A watchdog request gives an 8-cycle full pulse and sets cause bit 6 only when bit 1 is set. Otherwise it leaves both the outputs and the log unchanged.
- R4: A brown-out event gives an 8-cycle full pulse and sets cause bit 2 only when configuration bit 0 is set. The event always sets interrupt status bit 0.
- R5: Writing a value whose low 8 bits are 0x1B to offset 0x04 gives an 8-cycle `rst_partial_o` pulse and sets cause bit 4. It does not pulse `rst_full_o`. Any other low byte has no effect.
- R6: Writing a value whose low 8 bits are 0xD4 to offset 0x08 gives an 8-cycle full pulse and sets cause bit 3. Any other low byte has no effect.
- R7: Cause bits are sticky. A later reset adds its own bit and never clears earlier ones.
- R8: Writing 1 in bit 0 at offset 0x10 clears the whole log. A cause that arrives in the same cycle is still recorded.
- R9: Bit 0 at offset 0x14 drives `trace_rst_o` directly. Writing 1 asserts it and writing 0 releases it.
- R10: The interrupt registers use bit 0 at these offsets: 0x200 enable, 0x204 status, 0x208 write-1-clear, 0x20C write-1-set. `bod_irq_o` is high exactly when both status and enable are 1.
- R11: When a brown-out event and a write to the clear register fall in the same cycle, the status ends up set.
- R12: Reads return 0 at offsets 0x04, 0x08, 0x10, 0x208, 0x20C and at any unmapped offset.
- R13: A new accepted request during a pulse restarts the 8-cycle count. A second request 3 cycles after the first gives a pulse 11 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| ext_req_i | input | 1 | External reset request |
| bod_evt_i | input | 1 | Brown-out event |
| wdt_req_i | input | 1 | Watchdog reset request |
| dbg_req_i | input | 1 | Debugger reset request |
| sysreq_i | input | 1 | Processor system-reset request |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational |
| rst_full_o | output | 1 | Full-system reset pulse |
| rst_partial_o | output | 1 | Partial reset pulse |
| trace_rst_o | output | 1 | Static trace-port reset |
| bod_irq_o | output | 1 | Brown-out interrupt |

## Verification
Each request source is fired alone, so the log shows that every source sets exactly its own bit and that bits pile up without clearing one another. Watchdog and brown-out events are fired with their enables both off and on, which separates gating from plain recording. Key writes use the correct byte, a near-miss byte, and the correct byte with nonzero upper bits, which shows that only the low byte is compared. Clear-versus-cause and clear-versus-event collisions in the same cycle, together with a retrigger during a pulse, pin down the priority rules and the restart of the pulse length.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
    localparam int NCAUSE    = 7;
    localparam int C_EXT     = 0;
    localparam int C_PWR     = 1;
    localparam int C_BOD     = 2;
    localparam int C_SOFTFUL = 3;
    localparam int C_SOFTPRT = 4;
    localparam int C_DBG     = 5;
    localparam int C_WDT     = 6;

    localparam int OFF_CFG    = 'h000;
    localparam int OFF_KEYPRT = 'h004;
    localparam int OFF_KEYFUL = 'h008;
    localparam int OFF_CAUSE  = 'h00C;
    localparam int OFF_CLR    = 'h010;
    localparam int OFF_TRACE  = 'h014;
    localparam int OFF_IEN    = 'h200;
    localparam int OFF_ISTAT  = 'h204;
    localparam int OFF_ICLR   = 'h208;
    localparam int OFF_ISET   = 'h20C;

    localparam logic [7:0] KEY_PARTIAL = 8'h1B;
    localparam logic [7:0] KEY_FULL    = 8'hD4;

    typedef struct packed {
        logic wdt_en;
        logic bod_en;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic trace;
    } ctl_t;
endpackage

// File: rtl/rcc_stretch.sv
`timescale 1ns/1ps
module rcc_stretch #(
    parameter int LEN           = 8,
    parameter bit LOAD_AT_RESET = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOADV = CW'(LEN);
    localparam logic [CW-1:0] RSTV  = LOAD_AT_RESET ? LOADV : '0;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig_i)
            cnt_d = LOADV;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cnt_q <= RSTV;
        else          cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rcc_cause_log.sv
`timescale 1ns/1ps
module rcc_cause_log #(
    parameter int              N        = 7,
    parameter logic [N-1:0]    RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] log_o
);
    logic [N-1:0] log_d, log_q;

    always_comb begin
        log_d = clr_i ? '0 : log_q;
        log_d = log_d | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) log_q <= RESET_VAL;
        else          log_q <= log_d;
    end

    assign log_o = log_q;
endmodule

// File: rtl/rcc_bod_irq.sv
`timescale 1ns/1ps
module rcc_bod_irq (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic set_i,
    input  logic clr_i,
    output logic en_o,
    output logic stat_o,
    output logic irq_o
);
    typedef struct packed {
        logic en;
        logic stat;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) st_d.en = en_val_i;
        if (set_i)
            st_d.stat = 1'b1;
        else if (clr_i)
            st_d.stat = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign stat_o = st_q.stat;
    assign irq_o  = st_q.en & st_q.stat;
endmodule

// File: rtl/reset_cause_ctrl.sv
`timescale 1ns/1ps
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 8
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              ext_req_i,
    input  logic              bod_evt_i,
    input  logic              wdt_req_i,
    input  logic              dbg_req_i,
    input  logic              sysreq_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rst_full_o,
    output logic              rst_partial_o,
    output logic              trace_rst_o,
    output logic              bod_irq_o
);
    localparam int NDOM = 2;
    localparam logic [NDOM-1:0] DOM_LOAD = 2'b01;
    localparam logic [NCAUSE-1:0] LOG_RST = NCAUSE'(1) << C_PWR;

    ctl_t ctl_d, ctl_q;
    logic wr, rd;
    logic hit_cfg, hit_kprt, hit_kful, hit_cause, hit_clr, hit_trace;
    logic hit_ien, hit_istat, hit_iclr, hit_iset;
    logic poi_hit, por_key_hit, clr_hit;
    logic [NCAUSE-1:0] cause;
    logic [NCAUSE-1:0] log_q;
    logic [NDOM-1:0]   dom_trig, dom_act;
    logic irq_en, irq_stat;
    logic unused_wdata;

    assign wr = bus_sel_i & bus_wr_i;
    assign rd = bus_sel_i & ~bus_wr_i;

    assign hit_cfg   = (bus_addr_i == ADDR_W'(OFF_CFG));
    assign hit_kprt  = (bus_addr_i == ADDR_W'(OFF_KEYPRT));
    assign hit_kful  = (bus_addr_i == ADDR_W'(OFF_KEYFUL));
    assign hit_cause = (bus_addr_i == ADDR_W'(OFF_CAUSE));
    assign hit_clr   = (bus_addr_i == ADDR_W'(OFF_CLR));
    assign hit_trace = (bus_addr_i == ADDR_W'(OFF_TRACE));
    assign hit_ien   = (bus_addr_i == ADDR_W'(OFF_IEN));
    assign hit_istat = (bus_addr_i == ADDR_W'(OFF_ISTAT));
    assign hit_iclr  = (bus_addr_i == ADDR_W'(OFF_ICLR));
    assign hit_iset  = (bus_addr_i == ADDR_W'(OFF_ISET));

    assign poi_hit     = wr & hit_kprt & (bus_wdata_i[7:0] == KEY_PARTIAL);
    assign por_key_hit = wr & hit_kful & (bus_wdata_i[7:0] == KEY_FULL);
    assign clr_hit     = wr & hit_clr & bus_wdata_i[0];
    assign unused_wdata = ^bus_wdata_i[DATA_W-1:8];

    // control registers: configuration enables and trace-port reset
    always_comb begin
        ctl_d = ctl_q;
        if (wr && hit_cfg) begin
            ctl_d.cfg.bod_en = bus_wdata_i[0];
            ctl_d.cfg.wdt_en = bus_wdata_i[1];
        end
        if (wr && hit_trace) ctl_d.trace = bus_wdata_i[0];
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) ctl_q <= '0;
        else          ctl_q <= ctl_d;
    end

    // accepted causes this cycle
    always_comb begin
        cause            = '0;
        cause[C_EXT]     = ext_req_i;
        cause[C_BOD]     = bod_evt_i & ctl_q.cfg.bod_en;
        cause[C_SOFTFUL] = sysreq_i | por_key_hit;
        cause[C_SOFTPRT] = poi_hit;
        cause[C_DBG]     = dbg_req_i;
        cause[C_WDT]     = wdt_req_i & ctl_q.cfg.wdt_en;
    end

    assign dom_trig[0] = cause[C_EXT] | cause[C_BOD] | cause[C_SOFTFUL]
                       | cause[C_DBG] | cause[C_WDT];
    assign dom_trig[1] = cause[C_SOFTPRT];

    genvar gi;
    generate
        for (gi = 0; gi < NDOM; gi++) begin : g_dom
            rcc_stretch #(
                .LEN(PULSE_LEN),
                .LOAD_AT_RESET(DOM_LOAD[gi])
            ) u_stretch (
                .clk_i   (clk_i),
                .rst_n_i (por_n_i),
                .trig_i  (dom_trig[gi]),
                .active_o(dom_act[gi])
            );
        end
    endgenerate

    rcc_cause_log #(
        .N(NCAUSE),
        .RESET_VAL(LOG_RST)
    ) u_log (
        .clk_i  (clk_i),
        .rst_n_i(por_n_i),
        .set_i  (cause),
        .clr_i  (clr_hit),
        .log_o  (log_q)
    );

    rcc_bod_irq u_irq (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .en_wr_i (wr & hit_ien),
        .en_val_i(bus_wdata_i[0]),
        .set_i   (bod_evt_i | (wr & hit_iset & bus_wdata_i[0])),
        .clr_i   (wr & hit_iclr & bus_wdata_i[0]),
        .en_o    (irq_en),
        .stat_o  (irq_stat),
        .irq_o   (bod_irq_o)
    );

    // read mux; write-only and unmapped offsets return zero
    always_comb begin
        bus_rdata_o = '0;
        if (rd) begin
            if (hit_cfg)   bus_rdata_o[1:0] = {ctl_q.cfg.wdt_en, ctl_q.cfg.bod_en};
            if (hit_cause) bus_rdata_o[NCAUSE-1:0] = log_q;
            if (hit_trace) bus_rdata_o[0] = ctl_q.trace;
            if (hit_ien)   bus_rdata_o[0] = irq_en;
            if (hit_istat) bus_rdata_o[0] = irq_stat;
        end
    end

    assign rst_full_o    = dom_act[0];
    assign rst_partial_o = dom_act[1];
    assign trace_rst_o   = ctl_q.trace;
endmodule

// File: rtl/rcc_checker.sv
`timescale 1ns/1ps
module rcc_checker
    import rcc_pkg::*;
(
    input logic              clk_i,
    input logic              por_n_i,
    input logic              wdt_req_i,
    input logic              bod_evt_i,
    input cfg_t              cfg_q,
    input logic [NCAUSE-1:0] log_q,
    input logic              full_trig,
    input logic              poi_hit,
    input logic              clr_hit,
    input logic              irq_stat,
    input logic              trace_wr,
    input logic              trace_val,
    input logic              rst_full_o,
    input logic              rst_partial_o,
    input logic              trace_rst_o
);
    assert_full_starts_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        full_trig |=> rst_full_o);

    assert_wdt_gated_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(log_q[C_WDT]) |-> $past(wdt_req_i && cfg_q.wdt_en));

    assert_bod_gated_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(log_q[C_BOD]) |-> $past(bod_evt_i && cfg_q.bod_en));

    assert_partial_key_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(rst_partial_o) |-> $past(poi_hit));

    assert_log_sticky_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !clr_hit |=> ((log_q & $past(log_q)) == $past(log_q)));

    assert_trace_follows_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        trace_wr |=> (trace_rst_o == $past(trace_val)));

    assert_event_beats_clear_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
        bod_evt_i |=> irq_stat);
endmodule

bind reset_cause_ctrl rcc_checker u_rcc_checker (
    .clk_i        (clk_i),
    .por_n_i      (por_n_i),
    .wdt_req_i    (wdt_req_i),
    .bod_evt_i    (bod_evt_i),
    .cfg_q        (ctl_q.cfg),
    .log_q        (log_q),
    .full_trig    (dom_trig[0]),
    .poi_hit      (poi_hit),
    .clr_hit      (clr_hit),
    .irq_stat     (irq_stat),
    .trace_wr     (wr & hit_trace),
    .trace_val    (bus_wdata_i[0]),
    .rst_full_o   (rst_full_o),
    .rst_partial_o(rst_partial_o),
    .trace_rst_o  (trace_rst_o)
);

// File: tb/reset_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module reset_cause_ctrl_tb_top;
    localparam int AW = 12;
    localparam int DW = 32;

    typedef struct {
        int    val;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_req = 0, bod_evt = 0, wdt_req = 0, dbg_req = 0, sysreq = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic rst_full, rst_part, trace_rst, bod_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int full_run = 0;
    int part_run = 0;
    item_t exp_full[$];
    item_t exp_part[$];
    item_t exp_rd[$];

    always #4 clk = ~clk;

    reset_cause_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PULSE_LEN(8)) dut_i (
        .clk_i(clk), .por_n_i(por_n),
        .ext_req_i(ext_req), .bod_evt_i(bod_evt), .wdt_req_i(wdt_req),
        .dbg_req_i(dbg_req), .sysreq_i(sysreq),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .rst_full_o(rst_full), .rst_partial_o(rst_part),
        .trace_rst_o(trace_rst), .bod_irq_o(bod_irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic pop_cmp(inout item_t q[$], input int got, input string what);
        item_t it;
        if (q.size() == 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL %s: unexpected value 0x%0h, expected none", what, got);
        end else begin
            it = q.pop_front();
            check(it.tag, got, it.val);
        end
    endtask

    // monitor: samples 2 ns after each falling edge
    always @(negedge clk) begin
        #2;
        if (por_n) begin
            if (rst_full) full_run++;
            else if (full_run != 0) begin
                pop_cmp(exp_full, full_run, "full pulse");
                full_run = 0;
            end
            if (rst_part) part_run++;
            else if (part_run != 0) begin
                pop_cmp(exp_part, part_run, "partial pulse");
                part_run = 0;
            end
            if (bus_sel && !bus_wr) pop_cmp(exp_rd, int'(bus_rdata), "read");
        end
    end

    function automatic item_t mk(input int v, input string t);
        item_t it;
        it.val = v;
        it.tag = t;
        return it;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input int e, input string t);
        exp_rd.push_back(mk(e, t));
        bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic fire(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic run_tests();
        idle(3);
        exp_full.push_back(mk(8, "R1 power-on pulse"));
        por_n = 1'b1;
        idle(12);
        rd('h00C, 'h02, "R1 cause after power-on");
        rd('h000, 0, "R1 cfg reset");
        rd('h014, 0, "R1 trace reset");
        rd('h200, 0, "R1 irq enable reset");
        rd('h204, 0, "R1 irq status reset");
        check("R1 partial idle", int'(rst_part), 0);

        exp_full.push_back(mk(8, "R2 external pulse"));
        fire(ext_req); idle(12);
        rd('h00C, 'h03, "R2 external bit0 R7");
        exp_full.push_back(mk(8, "R2 debugger pulse"));
        fire(dbg_req); idle(12);
        rd('h00C, 'h23, "R2 debugger bit5 R7");
        exp_full.push_back(mk(8, "R2 sysreq pulse"));
        fire(sysreq); idle(12);
        rd('h00C, 'h2B, "R2 sysreq bit3 R7");

        wr('h010, 0); rd('h00C, 'h2B, "R8 clear bit0=0 ignored");
        wr('h010, 1); rd('h00C, 0, "R8 clear all");

        fire(wdt_req); idle(12);
        check("R3 wdt disabled no reset", int'(rst_full), 0);
        rd('h00C, 0, "R3 wdt disabled no cause");
        wr('h000, 3); rd('h000, 3, "R3 cfg readback");
        exp_full.push_back(mk(8, "R3 wdt enabled pulse"));
        fire(wdt_req); idle(12);
        rd('h00C, 'h40, "R3 wdt cause bit6");

        exp_full.push_back(mk(8, "R4 bod enabled pulse"));
        fire(bod_evt); idle(12);
        rd('h00C, 'h44, "R4 bod cause bit2");
        rd('h204, 1, "R4 bod sets irq status");
        check("R10 irq masked", int'(bod_irq), 0);
        wr('h000, 2); wr('h208, 1);
        rd('h204, 0, "R10 irq clear");
        fire(bod_evt); idle(12);
        rd('h00C, 'h44, "R4 bod disabled no cause");
        rd('h204, 1, "R4 bod disabled irq set");

        wr('h200, 1);
        check("R10 irq out enabled", int'(bod_irq), 1);
        wr('h208, 1);
        check("R10 irq out cleared", int'(bod_irq), 0);
        wr('h20C, 1);
        rd('h204, 1, "R10 irq set write");
        check("R10 irq out set", int'(bod_irq), 1);
        wr('h208, 1);
        bod_evt = 1'b1;
        wr('h208, 1);
        bod_evt = 1'b0;
        rd('h204, 1, "R11 event beats clear");
        check("R11 irq out", int'(bod_irq), 1);

        wr('h004, 'h1C); idle(12);
        check("R5 wrong key no partial", int'(rst_part), 0);
        rd('h00C, 'h44, "R5 wrong key no cause");
        exp_part.push_back(mk(8, "R5 partial key pulse"));
        wr('h004, 'h31B); idle(12);
        rd('h00C, 'h54, "R5 partial cause bit4");

        wr('h008, 'h1B); idle(12);
        rd('h00C, 'h54, "R6 wrong key no cause");
        exp_full.push_back(mk(8, "R6 full key pulse"));
        wr('h008, 'hD4); idle(12);
        rd('h00C, 'h5C, "R6 full cause bit3");

        exp_full.push_back(mk(8, "R8 clear with same-cycle cause pulse"));
        ext_req = 1'b1;
        wr('h010, 1);
        ext_req = 1'b0;
        idle(12);
        rd('h00C, 'h01, "R8 same-cycle cause kept");

        wr('h014, 1);
        check("R9 trace asserted", int'(trace_rst), 1);
        rd('h014, 1, "R9 trace readback");
        wr('h014, 0);
        check("R9 trace released", int'(trace_rst), 0);

        rd('h004, 0, "R12 partial key reads 0");
        rd('h008, 0, "R12 full key reads 0");
        rd('h010, 0, "R12 clear reads 0");
        rd('h208, 0, "R12 irq clear reads 0");
        rd('h20C, 0, "R12 irq set reads 0");
        rd('h018, 0, "R12 unmapped reads 0");
        rd('h100, 0, "R12 unmapped reads 0");

        exp_full.push_back(mk(11, "R13 retrigger restarts count"));
        fire(ext_req); idle(2); fire(ext_req); idle(16);
        rd('h00C, 'h01, "R13 cause unchanged");
        idle(2);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        while (exp_full.size() != 0) begin
            item_t it = exp_full.pop_front();
            n_tests++; n_fail++;
            $display("FAIL %s: got no pulse expected %0d", it.tag, it.val);
        end
        while (exp_part.size() != 0) begin
            item_t it = exp_part.pop_front();
            n_tests++; n_fail++;
            $display("FAIL %s: got no pulse expected %0d", it.tag, it.val);
        end
        while (exp_rd.size() != 0) begin
            item_t it = exp_rd.pop_front();
            n_tests++; n_fail++;
            $display("FAIL %s: got no read expected 0x%0h", it.tag, it.val);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule